// File: doc/BRIEF.md
# Memo Status Register Pair

This block holds two eight-bit status words, without parity, that record the handshake between a byte-wide peripheral holder, a host processor interface and a peer module. Each bit follows its own ownership rule. Some bits are raised by hardware events and lowered only by software. Some are raised only by software and lowered by hardware. One is a registered copy of a host access line. Others are raised by error detectors and can also be written by software. One busy flag belongs to hardware alone. The remaining bits are free scratch bits, together with an acknowledge-ready flag and a four-bit acknowledge code that are presented to a peer module.

Software reaches the words only through a masked store. One write strobe selects a word, and only the bits set in the mask may take the stored data. Whether a selected bit actually changes still depends on that bit's rule. Both words are always visible on output ports, and software tests a bit by ANDing the word it reads. When a hardware event and a software store act on the same bit in the same cycle, the hardware event wins.

Top module: `memo_status_regs`

## Requirements
- R1: While rst_ni is low, both words read 0x00 and the peer outputs are zero.
- R2: A store changes only the bits whose mask bit is 1. The free bits (word 1 bits 7:6 and word 2 bits 2:1, LSB = bit 0) take the stored value, and unmasked bits keep their value.
- R3: Word 1 bit 0 (character present) becomes 1 the cycle after char_arrive_i. A masked store of 0 clears it, and a masked store of 1 has no effect.
- R4: Word 1 bit 1 (device ready) is set by a masked store of 1 and cleared by out_holder_empty_i. A store of 0 has no effect. If a clear and a set arrive in the same cycle, the clear wins.
- R5: Word 1 bit 2 (message available) is set by a masked store of 1 and cleared by host_xfer_done_i, with the clear winning. A store of 0 has no effect.
- R6: Word 1 bit 3 shows the value that host_access_i had at the previous clock edge. Stores do not change it.
- R7: Word 1 bit 4 (internal error) is set by instr_par_err_i, input_par_err_i or host_par_err_i. A masked store can set or clear it.
- R8: Word 1 bit 5 (interface error) is set by holder_par_err_i. A masked store can set or clear it.
- R9: A hardware set and a software clear of the same bit in the same cycle leave the bit at 1.
- R10: Word 2 bit 0 (message track busy) is set by mt_busy_set_i and cleared by mt_busy_clr_i. Set wins when both arrive together, and stores never change it.
- R11: Word 2 bit 3 (acknowledge ready) and bits 7:4 (acknowledge code) are freely written by masked stores. They are driven on peer_ack_ready_o and peer_ack_code_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sw_we_i | input | 1 | Software store strobe |
| sw_sel_i | input | 1 | Store target: 0 = word 1, 1 = word 2 |
| sw_data_i | input | 8 | Store data |
| sw_mask_i | input | 8 | Store bit mask |
| char_arrive_i | input | 1 | Input character arrived in holder |
| out_holder_empty_i | input | 1 | Output holder emptied |
| host_xfer_done_i | input | 1 | Host finished message transfer |
| host_access_i | input | 1 | Host access line |
| instr_par_err_i | input | 1 | Instruction word parity error |
| input_par_err_i | input | 1 | Input-to-accumulator parity error |
| host_par_err_i | input | 1 | Host transfer parity error |
| holder_par_err_i | input | 1 | Input holder parity error |
| mt_busy_set_i | input | 1 | Message track busy start |
| mt_busy_clr_i | input | 1 | Message track busy end |
| memo1_o | output | 8 | Word 1 contents |
| memo2_o | output | 8 | Word 2 contents |
| peer_ack_ready_o | output | 1 | Acknowledge ready to peer |
| peer_ack_code_o | output | 4 | Acknowledge code to peer |

## Verification
The bench aims at the same-cycle collisions. A hardware set is paired with a software clear, a hardware clear with a software set, and the busy flag's set with its clear. A design with the priority reversed would leave the bit in the wrong state for as long as the bit then holds. Stores of the forbidden polarity go to the one-way bits, so a design that treated them as plain read/write bits would set character present or clear device ready by software. Stores with sparse masks show whether unmasked neighbours were disturbed. Toggling the host line shows whether its mirror is late, early or writable.

// File: rtl/memo_pkg.sv
package memo_pkg;
  localparam int MEMO_W = 8;
  localparam int ACK_W  = 4;
  localparam int POL_W  = 3;

  typedef enum logic [POL_W-1:0] {
    POL_SW_RW        = 3'd0,
    POL_HW_SET_SW_CLR = 3'd1,
    POL_SW_SET_HW_CLR = 3'd2,
    POL_MIRROR       = 3'd3,
    POL_SW_RW_HW_SET = 3'd4,
    POL_HW_ONLY      = 3'd5
  } memo_pol_e;

  // word 1 bit positions
  localparam int B1_CHAR  = 0;
  localparam int B1_DEVRDY = 1;
  localparam int B1_MSGAV = 2;
  localparam int B1_XFEROP = 3;
  localparam int B1_INTERR = 4;
  localparam int B1_IFERR = 5;
  // word 2 bit positions
  localparam int B2_MTBUSY = 0;
  localparam int B2_ACKRDY = 3;
  localparam int B2_ACKLSB = 4;

  // policy vectors, bit 7 first
  localparam logic [MEMO_W*POL_W-1:0] MEMO1_POL = {
    POL_SW_RW, POL_SW_RW, POL_SW_RW_HW_SET, POL_SW_RW_HW_SET,
    POL_MIRROR, POL_SW_SET_HW_CLR, POL_SW_SET_HW_CLR, POL_HW_SET_SW_CLR};
  localparam logic [MEMO_W*POL_W-1:0] MEMO2_POL = {
    POL_SW_RW, POL_SW_RW, POL_SW_RW, POL_SW_RW,
    POL_SW_RW, POL_SW_RW, POL_SW_RW, POL_HW_ONLY};
endpackage

// File: rtl/memo_bit_cell.sv
module memo_bit_cell
  import memo_pkg::*;
#(
  parameter memo_pol_e POL = POL_SW_RW
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_set_i,
  input  logic hw_clr_i,
  input  logic mirror_i,
  input  logic sw_we_i,
  input  logic sw_val_i,
  output logic q_o
);
  logic q_q, q_d;

  always_comb begin
    q_d = q_q;
    case (POL)
      POL_HW_SET_SW_CLR: begin
        if (hw_set_i)                  q_d = 1'b1;
        else if (sw_we_i && !sw_val_i) q_d = 1'b0;
      end
      POL_SW_SET_HW_CLR: begin
        if (hw_clr_i)                 q_d = 1'b0;
        else if (sw_we_i && sw_val_i) q_d = 1'b1;
      end
      POL_MIRROR:        q_d = mirror_i;
      POL_SW_RW_HW_SET: begin
        if (hw_set_i)     q_d = 1'b1;
        else if (sw_we_i) q_d = sw_val_i;
      end
      POL_HW_ONLY: begin
        if (hw_set_i)      q_d = 1'b1;
        else if (hw_clr_i) q_d = 1'b0;
      end
      default: if (sw_we_i) q_d = sw_val_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  generate
    if (POL == POL_HW_SET_SW_CLR) begin : g_ast_hs
      AST_HW_SET_BEATS_SW: assert property (@(posedge clk_i) disable iff (!rst_ni) hw_set_i |=> q_o); // R9
      AST_NO_SW_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni) (!q_o && !hw_set_i) |=> !q_o); // R3
    end else if (POL == POL_SW_SET_HW_CLR) begin : g_ast_ss
      AST_HW_CLR_BEATS_SW: assert property (@(posedge clk_i) disable iff (!rst_ni) hw_clr_i |=> !q_o); // R4
      AST_NO_SW_LOWER: assert property (@(posedge clk_i) disable iff (!rst_ni) (q_o && !hw_clr_i) |=> q_o); // R4
    end else if (POL == POL_MIRROR) begin : g_ast_mi
      AST_MIRROR_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni) rst_ni |=> (q_o == $past(mirror_i))); // R6
    end else if (POL == POL_SW_RW_HW_SET) begin : g_ast_er
      AST_ERR_SET_BEATS_SW: assert property (@(posedge clk_i) disable iff (!rst_ni) hw_set_i |=> q_o); // R9
    end else if (POL == POL_HW_ONLY) begin : g_ast_ho
      AST_BUSY_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni) hw_set_i |=> q_o); // R10
      AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (!hw_set_i && !hw_clr_i) |=> $stable(q_o)); // R10
    end else begin : g_ast_rw
      AST_OPEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !sw_we_i |=> $stable(q_o)); // R2
    end
  endgenerate
endmodule

// File: rtl/memo_bank.sv
module memo_bank
  import memo_pkg::*;
#(
  parameter int                      W       = MEMO_W,
  parameter logic [W*POL_W-1:0]      POL_VEC = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] hw_set_i,
  input  logic [W-1:0] hw_clr_i,
  input  logic [W-1:0] mirror_i,
  input  logic         sw_we_i,
  input  logic [W-1:0] sw_data_i,
  input  logic [W-1:0] sw_mask_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] bit_we;
  assign bit_we = {W{sw_we_i}} & sw_mask_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam memo_pol_e P = memo_pol_e'(POL_VEC[POL_W*i +: POL_W]);
    memo_bit_cell #(.POL(P)) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hw_set_i (hw_set_i[i]),
      .hw_clr_i (hw_clr_i[i]),
      .mirror_i (mirror_i[i]),
      .sw_we_i  (bit_we[i]),
      .sw_val_i (sw_data_i[i]),
      .q_o      (q_o[i])
    );
  end

  // unmasked bits never move on a store alone
  AST_UNMASKED_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_we_i && sw_mask_i == '0 && hw_set_i == '0 && hw_clr_i == '0 && mirror_i == '0
     && $past(mirror_i) == '0) |=> $stable(q_o)); // R2
endmodule

// File: rtl/memo_hw_events.sv
module memo_hw_events
  import memo_pkg::*;
(
  input  logic              char_arrive_i,
  input  logic              out_holder_empty_i,
  input  logic              host_xfer_done_i,
  input  logic              host_access_i,
  input  logic              instr_par_err_i,
  input  logic              input_par_err_i,
  input  logic              host_par_err_i,
  input  logic              holder_par_err_i,
  input  logic              mt_busy_set_i,
  input  logic              mt_busy_clr_i,
  output logic [MEMO_W-1:0] set1_o,
  output logic [MEMO_W-1:0] clr1_o,
  output logic [MEMO_W-1:0] mir1_o,
  output logic [MEMO_W-1:0] set2_o,
  output logic [MEMO_W-1:0] clr2_o
);
  always_comb begin
    set1_o = '0;
    clr1_o = '0;
    mir1_o = '0;
    set2_o = '0;
    clr2_o = '0;
    set1_o[B1_CHAR]   = char_arrive_i;
    set1_o[B1_INTERR] = instr_par_err_i | input_par_err_i | host_par_err_i;
    set1_o[B1_IFERR]  = holder_par_err_i;
    clr1_o[B1_DEVRDY] = out_holder_empty_i;
    clr1_o[B1_MSGAV]  = host_xfer_done_i;
    mir1_o[B1_XFEROP] = host_access_i;
    set2_o[B2_MTBUSY] = mt_busy_set_i;
    clr2_o[B2_MTBUSY] = mt_busy_clr_i;
  end
endmodule

// File: rtl/memo_status_regs.sv
module memo_status_regs
  import memo_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_we_i,
  input  logic              sw_sel_i,
  input  logic [MEMO_W-1:0] sw_data_i,
  input  logic [MEMO_W-1:0] sw_mask_i,
  input  logic              char_arrive_i,
  input  logic              out_holder_empty_i,
  input  logic              host_xfer_done_i,
  input  logic              host_access_i,
  input  logic              instr_par_err_i,
  input  logic              input_par_err_i,
  input  logic              host_par_err_i,
  input  logic              holder_par_err_i,
  input  logic              mt_busy_set_i,
  input  logic              mt_busy_clr_i,
  output logic [MEMO_W-1:0] memo1_o,
  output logic [MEMO_W-1:0] memo2_o,
  output logic              peer_ack_ready_o,
  output logic [ACK_W-1:0]  peer_ack_code_o
);
  logic [MEMO_W-1:0] set1, clr1, mir1, set2, clr2;
  logic              we1, we2;

  assign we1 = sw_we_i & ~sw_sel_i;
  assign we2 = sw_we_i &  sw_sel_i;

  memo_hw_events u_events (
    .char_arrive_i      (char_arrive_i),
    .out_holder_empty_i (out_holder_empty_i),
    .host_xfer_done_i   (host_xfer_done_i),
    .host_access_i      (host_access_i),
    .instr_par_err_i    (instr_par_err_i),
    .input_par_err_i    (input_par_err_i),
    .host_par_err_i     (host_par_err_i),
    .holder_par_err_i   (holder_par_err_i),
    .mt_busy_set_i      (mt_busy_set_i),
    .mt_busy_clr_i      (mt_busy_clr_i),
    .set1_o             (set1),
    .clr1_o             (clr1),
    .mir1_o             (mir1),
    .set2_o             (set2),
    .clr2_o             (clr2)
  );

  memo_bank #(.W(MEMO_W), .POL_VEC(MEMO1_POL)) u_bank1 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_set_i  (set1),
    .hw_clr_i  (clr1),
    .mirror_i  (mir1),
    .sw_we_i   (we1),
    .sw_data_i (sw_data_i),
    .sw_mask_i (sw_mask_i),
    .q_o       (memo1_o)
  );

  memo_bank #(.W(MEMO_W), .POL_VEC(MEMO2_POL)) u_bank2 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_set_i  (set2),
    .hw_clr_i  (clr2),
    .mirror_i  ('0),
    .sw_we_i   (we2),
    .sw_data_i (sw_data_i),
    .sw_mask_i (sw_mask_i),
    .q_o       (memo2_o)
  );

  assign peer_ack_ready_o = memo2_o[B2_ACKRDY];
  assign peer_ack_code_o  = memo2_o[B2_ACKLSB +: ACK_W];

  AST_RESET_CLEAR: assert property (@(posedge clk_i) !rst_ni |-> (memo1_o == '0 && memo2_o == '0)); // R1
  AST_XFEROP_NOT_WRITABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_access_i && !memo1_o[B1_XFEROP]) |=> !memo1_o[B1_XFEROP]); // R6
  AST_ACK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we2 && sw_mask_i[B2_ACKLSB +: ACK_W] == '1) |=> peer_ack_code_o == $past(sw_data_i[B2_ACKLSB +: ACK_W])); // R11
  AST_INTERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_par_err_i || input_par_err_i || host_par_err_i) |=> memo1_o[B1_INTERR]); // R7
  AST_IFERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    holder_par_err_i |=> memo1_o[B1_IFERR]); // R8
  AST_MSGAV_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_xfer_done_i |=> !memo1_o[B1_MSGAV]); // R5
endmodule

// File: tb/tb_memo_status_regs.sv
`timescale 1ns/1ps
module tb_memo_status_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 0, sel = 0;
  logic [7:0] data = 0, mask = 0;
  logic ch = 0, oe = 0, xd = 0, ha = 0, ipe = 0, npe = 0, hpe = 0, hle = 0, bs = 0, bc = 0;
  logic [7:0] m1, m2;
  logic ar;
  logic [3:0] ac;

  int vectors = 0;
  int miscompares = 0;
  string force_tag = "";
  logic [7:0] e1 = 0, e2 = 0;

  always #2.5 clk = ~clk;

  memo_status_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .sw_we_i(we), .sw_sel_i(sel), .sw_data_i(data), .sw_mask_i(mask),
    .char_arrive_i(ch), .out_holder_empty_i(oe), .host_xfer_done_i(xd), .host_access_i(ha),
    .instr_par_err_i(ipe), .input_par_err_i(npe), .host_par_err_i(hpe), .holder_par_err_i(hle),
    .mt_busy_set_i(bs), .mt_busy_clr_i(bc),
    .memo1_o(m1), .memo2_o(m2), .peer_ack_ready_o(ar), .peer_ack_code_o(ac));

  function automatic string req_of(int w, int b);
    if (force_tag != "") return force_tag;
    if (w == 1) begin
      case (b)
        0: return "R3"; 1: return "R4"; 2: return "R5"; 3: return "R6";
        4: return "R7"; 5: return "R8"; default: return "R2";
      endcase
    end
    case (b)
      0: return "R10"; 1, 2: return "R2"; default: return "R11";
    endcase
  endfunction

  // behavioural reference, evaluated on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e1 = 0; e2 = 0;
    end else begin
      bit w1, w2;
      logic [7:0] n1, n2;
      w1 = we && !sel; w2 = we && sel;
      n1 = e1; n2 = e2;
      for (int b = 0; b < 8; b++) begin
        bit hit1, hit2;
        hit1 = w1 && mask[b]; hit2 = w2 && mask[b];
        case (b)
          0: if (ch) n1[0] = 1; else if (hit1 && !data[0]) n1[0] = 0;
          1: if (oe) n1[1] = 0; else if (hit1 && data[1]) n1[1] = 1;
          2: if (xd) n1[2] = 0; else if (hit1 && data[2]) n1[2] = 1;
          3: n1[3] = ha;
          4: if (ipe || npe || hpe) n1[4] = 1; else if (hit1) n1[4] = data[4];
          5: if (hle) n1[5] = 1; else if (hit1) n1[5] = data[5];
          default: if (hit1) n1[b] = data[b];
        endcase
        if (b == 0) begin
          if (bs) n2[0] = 1; else if (bc) n2[0] = 0;
        end else if (hit2) n2[b] = data[b];
      end
      e1 = n1; e2 = n2;
    end
  end

  task automatic compare();
    vectors++;
    for (int b = 0; b < 8; b++) begin
      if (m1[b] !== e1[b]) begin
        miscompares++;
        $display("FAIL %s word1 bit%0d actual=%b expected=%b t=%0t", req_of(1, b), b, m1[b], e1[b], $time);
      end
      if (m2[b] !== e2[b]) begin
        miscompares++;
        $display("FAIL %s word2 bit%0d actual=%b expected=%b t=%0t", req_of(2, b), b, m2[b], e2[b], $time);
      end
    end
    if (ar !== e2[3] || ac !== e2[7:4]) begin // R11
      miscompares++;
      $display("FAIL R11 peer actual=%b/%h expected=%b/%h", ar, ac, e2[3], e2[7:4]);
    end
  endtask

  task automatic idle();
    we = 0; sel = 0; data = 0; mask = 0;
    ch = 0; oe = 0; xd = 0; ipe = 0; npe = 0; hpe = 0; hle = 0; bs = 0; bc = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
    idle();
  endtask

  task automatic store(logic s, logic [7:0] d, logic [7:0] m);
    we = 1; sel = s; data = d; mask = m;
  endtask

  initial begin
    #2000000;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1: reset state, with stimulus active
    force_tag = "R1";
    store(0, 8'hFF, 8'hFF); ch = 1; bs = 1; ha = 1;
    repeat (3) @(negedge clk);
    compare(); compare();
    @(negedge clk); rst_n = 1; idle(); ha = 0;
    force_tag = "";
    tick();
    // R2: free bits, masked store
    store(0, 8'hFF, 8'hC0); tick();
    store(0, 8'h00, 8'h40); tick();
    store(1, 8'hFF, 8'h06); tick();
    store(1, 8'h00, 8'h02); tick();
    store(0, 8'hFF, 8'h00); tick();
    // R3: character present
    ch = 1; tick();
    store(0, 8'hFF, 8'h01); tick();
    store(0, 8'h00, 8'h01); tick();
    store(0, 8'hFF, 8'h01); tick();
    // R4: device ready
    store(0, 8'h02, 8'h02); tick();
    store(0, 8'h00, 8'h02); tick();
    oe = 1; tick();
    store(0, 8'h02, 8'h02); oe = 1; tick();
    store(0, 8'h02, 8'h02); tick();
    // R5: message available
    store(0, 8'h04, 8'h04); tick();
    store(0, 8'h00, 8'h04); tick();
    xd = 1; store(0, 8'h04, 8'h04); tick();
    // R6: host access mirror
    ha = 1; tick(); tick();
    store(0, 8'h00, 8'h08); tick();
    ha = 0; store(0, 8'hFF, 8'h08); tick(); tick();
    // R7, R8: error bits
    ipe = 1; tick(); store(0, 8'h00, 8'h10); tick();
    npe = 1; tick(); store(0, 8'h00, 8'h10); tick();
    hpe = 1; tick(); store(0, 8'h00, 8'h30); tick();
    store(0, 8'h30, 8'h30); tick();
    store(0, 8'h00, 8'h30); tick();
    hle = 1; tick();
    // R9: hardware set beats software clear
    force_tag = "R9";
    store(0, 8'h00, 8'h31); ch = 1; ipe = 1; hle = 1; tick();
    store(0, 8'h00, 8'h31); hpe = 1; tick();
    force_tag = "";
    // R10: busy flag
    bs = 1; tick();
    store(1, 8'h00, 8'h01); tick();
    bs = 1; bc = 1; tick();
    bc = 1; tick();
    store(1, 8'hFF, 8'h01); tick();
    // R11: acknowledge ready and code
    store(1, 8'hA8, 8'hF8); tick();
    store(1, 8'h50, 8'h30); tick();
    store(1, 8'h00, 8'h08); tick();
    // random traffic
    for (int i = 0; i < 600; i++) begin
      we = ($urandom_range(0, 2) == 0); sel = $urandom_range(0, 1);
      data = 8'($urandom); mask = 8'($urandom);
      ch = ($urandom_range(0, 5) == 0); oe = ($urandom_range(0, 5) == 0);
      xd = ($urandom_range(0, 5) == 0); ha = $urandom_range(0, 1);
      ipe = ($urandom_range(0, 9) == 0); npe = ($urandom_range(0, 9) == 0);
      hpe = ($urandom_range(0, 9) == 0); hle = ($urandom_range(0, 7) == 0);
      bs = ($urandom_range(0, 4) == 0); bc = ($urandom_range(0, 4) == 0);
      @(negedge clk);
      compare();
    end
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule